// File: doc/BRIEF.md
# Accumulator Fetch-Decode-Execute Core

This block is a small multicycle processor built around a single accumulator. It runs one instruction at a time. Instructions and data come from one shared memory, and both use the same word format. Each instruction moves through a set of explicit registers:

- a program counter;
- a memory address register, the only source of the memory address;
- a memory data register, the only path for data to and from memory;
- a current-instruction register;
- the accumulator.

The memory is external and synchronous. The core presents an address from its address register. The read word comes back one cycle later. A write strobe commits the data register to memory at the next clock edge.

The instruction set covers the following:

- load, store, add and subtract against memory;
- an unconditional branch, a branch on zero and a branch on non-negative;
- a handshaked input transfer;
- a strobed output transfer;
- halt.

Once it halts, the core freezes and raises a halted flag until reset. The block is meant to be paired with a single-port block RAM that holds a preloaded program.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `mem_addr` is 0, `mem_we`, `in_ready`, `out_valid` and `halted` are 0, and the first instruction is fetched from address 0.
- R2: A fetch takes four cycles, in this order:
  1. The address register takes the program counter.
  2. The memory is read at that address, and the counter increments in the same cycle.
  3. The returned word is latched into the data register.
  4. The data register is copied into the instruction register.

  Execute follows in a fifth cycle. A lone HLT at address 0 therefore raises `halted` exactly 5 cycles after reset falls.
- R3: A word is 12 bits. Bits [11:8] are the opcode and bits [7:0] are an 8-bit memory address operand. Memory reads have a latency of one cycle.
- R4: ADD (opcode 1) and SUB (opcode 2) replace the accumulator with the accumulator plus or minus memory[operand], modulo 4096.
- R5: LDA (opcode 5) loads the accumulator from memory[operand]. STA (opcode 3) asserts `mem_we` for exactly one cycle with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator. An LDA followed by HLT halts 13 cycles after reset.
- R6: BRA (opcode 6) always loads the program counter with the operand.
- R7: BRZ (opcode 7) loads the program counter with the operand only when the accumulator is 0.
- R8: BRP (opcode 8) loads the program counter with the operand only when accumulator bit 11 is 0.
- R9: INP (opcode 9, operand 1) waits in execute until `in_valid` is high. It then copies `in_data` into the accumulator and pulses `in_ready` high for one cycle, in the cycle after the capture. Nothing else progresses while it waits.
- R10: OUT (opcode 9, operand 2) places the accumulator on `out_data` with `out_valid` high for exactly one cycle.
- R11: HLT (opcode 0) raises `halted`, which stays high until reset. While halted, `mem_addr` is stable and no write or output strobe occurs. Words after the HLT are never executed.
- R12: Opcodes 4 and 10 to 15, and opcode 9 with any operand other than 1 or 2, change nothing but the program counter. They leave the accumulator and memory unchanged and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address, driven from the address register |
| mem_wdata | output | 12 | Memory write data, driven from the data register |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 12 | Memory read data, one cycle after the address |
| in_valid | input | 1 | Input word available |
| in_data | input | 12 | Input word |
| in_ready | output | 1 | One-cycle pulse: input word taken |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 12 | Output word |
| halted | output | 1 | Core has executed HLT |

## Verification
Every visible effect comes from a short program: memory contents after a store, output words, and the halt time. A corrupted state therefore surfaces at the ports within a few instructions, and at most tens of cycles.

- **Wrong program counter or instruction register.** A wrong path is taken. This shows as a wrong marker word stored at a fixed location, or as extra or missing output strobes.
- **Wrong accumulator or ALU.** The stored sums and differences differ from the values the bench computes.
- **Miscounted fetch sequence.** The halt cycle moves away from the exact counts of 5 and 13.
- **Leaking halt state.** Writes, strobes or a moving address appear after `halted` rises.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_STA = 4'd3,
    OP_LDA = 4'd5,
    OP_BRA = 4'd6,
    OP_BRZ = 4'd7,
    OP_BRP = 4'd8,
    OP_IO  = 4'd9
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FWAIT,
    ST_FLATCH,
    ST_DECODE,
    ST_EXEC,
    ST_OWAIT,
    ST_OLATCH,
    ST_ALU,
    ST_WRITE,
    ST_HALT
  } state_e;

  localparam int IO_SEL_IN  = 1;
  localparam int IO_SEL_OUT = 2;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/acc_branch.sv
module acc_branch #(
  parameter int W = 12
) (
  input  logic [acc_core_pkg::OPC_W-1:0] op,
  input  logic [W-1:0]                   acc,
  output logic                           take
);
  import acc_core_pkg::*;
  always_comb begin
    case (op)
      OP_BRA:  take = 1'b1;
      OP_BRZ:  take = (acc == '0);
      OP_BRP:  take = ~acc[W-1];
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 12
) (
  input  logic                                   clk,
  input  logic                                   rst,
  output logic [DATA_W-acc_core_pkg::OPC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]                      mem_wdata,
  output logic                                   mem_we,
  input  logic [DATA_W-1:0]                      mem_rdata,
  input  logic                                   in_valid,
  input  logic [DATA_W-1:0]                      in_data,
  output logic                                   in_ready,
  output logic                                   out_valid,
  output logic [DATA_W-1:0]                      out_data,
  output logic                                   halted
);
  import acc_core_pkg::*;

  localparam int ADDR_W = DATA_W - OPC_W;

  state_e              state;
  logic [ADDR_W-1:0]   pc;
  logic [ADDR_W-1:0]   mar;
  logic [DATA_W-1:0]   mdr;
  logic [DATA_W-1:0]   cir;
  logic [DATA_W-1:0]   acc;

  // decode: split instruction register into fields
  logic [OPC_W-1:0]    op;
  logic [ADDR_W-1:0]   operand;
  assign op      = cir[DATA_W-1 -: OPC_W];
  assign operand = cir[ADDR_W-1:0];

  logic [DATA_W-1:0]   alu_y;
  logic                br_take;

  acc_alu #(.W(DATA_W)) u_alu (
    .a   (acc),
    .b   (mdr),
    .sub (op == OP_SUB),
    .y   (alu_y)
  );

  acc_branch #(.W(DATA_W)) u_branch (
    .op   (op),
    .acc  (acc),
    .take (br_take)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FADDR;
      pc        <= '0;
      mar       <= '0;
      mdr       <= '0;
      cir       <= '0;
      acc       <= '0;
      mem_we    <= 1'b0;
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      case (state)
        ST_FADDR: begin
          mar   <= pc;
          state <= ST_FWAIT;
        end
        ST_FWAIT: begin
          pc    <= pc + 1'b1;
          state <= ST_FLATCH;
        end
        ST_FLATCH: begin
          mdr   <= mem_rdata;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          cir   <= mdr;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FADDR;
          case (op)
            OP_ADD, OP_SUB, OP_LDA: begin
              mar   <= operand;
              state <= ST_OWAIT;
            end
            OP_STA: begin
              mar    <= operand;
              mdr    <= acc;
              mem_we <= 1'b1;
              state  <= ST_WRITE;
            end
            OP_BRA, OP_BRZ, OP_BRP: begin
              if (br_take) pc <= operand;
            end
            OP_IO: begin
              if (operand == ADDR_W'(IO_SEL_IN)) begin
                if (in_valid) begin
                  acc      <= in_data;
                  in_ready <= 1'b1;
                end else begin
                  state <= ST_EXEC;
                end
              end else if (operand == ADDR_W'(IO_SEL_OUT)) begin
                out_data  <= acc;
                out_valid <= 1'b1;
              end
            end
            OP_HLT: begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
            default: ;
          endcase
        end
        ST_OWAIT:  state <= ST_OLATCH;
        ST_OLATCH: begin
          mdr   <= mem_rdata;
          state <= ST_ALU;
        end
        ST_ALU: begin
          acc   <= (op == OP_LDA) ? mdr : alu_y;
          state <= ST_FADDR;
        end
        ST_WRITE: state <= ST_FADDR;
        ST_HALT:  state <= ST_HALT;
        default:  state <= ST_FADDR;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 12
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic [DATA_W-acc_core_pkg::OPC_W-1:0] mem_addr,
  input logic                                  mem_we,
  input logic                                  in_valid,
  input logic                                  in_ready,
  input logic                                  out_valid,
  input logic                                  halted,
  input acc_core_pkg::state_e                  state,
  input logic [DATA_W-acc_core_pkg::OPC_W-1:0] pc
);
  import acc_core_pkg::*;

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FWAIT) |-> (mem_addr == pc));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FWAIT) |=> (pc == $past(pc) + 1'b1));

  assert_we_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  assert_ready_after_valid_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> $past(in_valid));

  assert_out_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(mem_addr) && !mem_we && !out_valid));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .halted    (halted),
  .state     (state),
  .pc        (pc)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int AW = 8;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          halted;

  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;
  int out_n = 0;
  int rdy_n = 0;
  logic [DW-1:0] out_log [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .halted(halted)
  );

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    cyc_total <= cyc_total + 1;
    if (out_valid) begin
      if (out_n < 8) out_log[out_n] = out_data;
      out_n = out_n + 1;
    end
    if (in_ready) rdy_n = rdy_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] w(input int op, input int arg);
    return DW'((op << 8) | (arg & 8'hFF));
  endfunction

  function automatic logic [DW-1:0] val(input int i);
    case (i)
      0: return 12'h000;  1: return 12'h001;  2: return 12'h002;
      3: return 12'h7FF;  4: return 12'h800;  5: return 12'hFFE;
      6: return 12'hFFF;  default: return 12'h555;
    endcase
  endfunction

  task automatic load(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int a = 0; a < 64; a++) load(a, '0);
    load(255, '0);
  endtask

  // release reset and wait for halt; returns cycles to halt (-1 on timeout)
  task automatic run(output int cyc);
    @(negedge clk);
    ld_en = 1'b0;
    out_n = 0; rdy_n = 0;
    rst = 1'b0;
    cyc = -1;
    for (int c = 1; c <= 2000; c++) begin
      @(negedge clk);
      if (halted) begin cyc = c; break; end
    end
  endtask

  initial begin : watchdog
    wait (cyc_total >= WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc_total, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    int exp;
    logic [DW-1:0] a, b, v, addr0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(mem_addr == 0 && !mem_we && !in_ready && !out_valid && !halted,
        "R1 reset outputs", {mem_addr, mem_we, in_ready, out_valid, halted}, 0);

    // R2 timing: lone HLT at 0
    clear_mem();
    run(cyc);
    chk(cyc == 5, "R2 HLT halt cycle", cyc, 5);

    // R5 timing: LDA then HLT
    clear_mem();
    load(0, w(5, 40));
    run(cyc);
    chk(cyc == 13, "R5 LDA+HLT halt cycle", cyc, 13);

    // R4/R5 add/sub sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = val(i); b = val(j);
        clear_mem();
        load(0, w(5, 40)); load(1, w(1, 41)); load(2, w(3, 42));
        load(3, w(5, 40)); load(4, w(2, 41)); load(5, w(3, 43));
        load(40, a); load(41, b);
        run(cyc);
        chk(mem[42] == DW'(a + b), "R4 ADD result", mem[42], DW'(a + b));
        chk(mem[43] == DW'(a - b), "R4 SUB result", mem[43], DW'(a - b));
      end
    end

    // R3 full 8-bit operand on store
    clear_mem();
    load(0, w(5, 40)); load(1, w(3, 255)); load(40, 12'hABC);
    run(cyc);
    chk(mem[255] == 12'hABC, "R3 STA operand 255", mem[255], 12'hABC);

    // R6 R7 R8 branch sweep
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++) begin
        v = val(i);
        clear_mem();
        load(0, w(5, 45)); load(1, w(6 + k, 5));
        load(2, w(5, 46)); load(3, w(3, 47));
        load(5, w(5, 48)); load(6, w(3, 47));
        load(45, v); load(46, 12'd1); load(48, 12'd2);
        run(cyc);
        if (k == 0) exp = 2;
        else if (k == 1) exp = (v == 0) ? 2 : 1;
        else exp = (v[DW-1] == 1'b0) ? 2 : 1;
        if (k == 0) chk(mem[47] == DW'(exp), "R6 BRA taken", mem[47], exp);
        else if (k == 1) chk(mem[47] == DW'(exp), "R7 BRZ decision", mem[47], exp);
        else chk(mem[47] == DW'(exp), "R8 BRP decision", mem[47], exp);
      end
    end

    // R9 R10 input handshake and output strobe
    for (int i = 0; i < 4; i++) begin
      v = val(i + 3);
      clear_mem();
      load(0, w(9, 1)); load(1, w(9, 2)); load(2, w(1, 40));
      load(3, w(9, 2)); load(40, 12'h123);
      @(negedge clk);
      ld_en = 1'b0; out_n = 0; rdy_n = 0; rst = 1'b0;
      repeat (20 + i * 7) @(negedge clk);
      chk(out_n == 0 && rdy_n == 0 && !halted, "R9 stall without valid",
          out_n + rdy_n, 0);
      in_valid = 1'b1; in_data = v;
      cyc = 0;
      while (!in_ready && cyc < 50) begin @(negedge clk); cyc++; end
      in_valid = 1'b0; in_data = '0;
      cyc = 0;
      while (!halted && cyc < 200) begin @(negedge clk); cyc++; end
      chk(rdy_n == 1, "R9 ready single pulse", rdy_n, 1);
      chk(out_n == 2, "R10 output strobe count", out_n, 2);
      chk(out_log[0] == v, "R10 OUT of input word", out_log[0], v);
      chk(out_log[1] == DW'(v + 12'h123), "R10 OUT after ADD", out_log[1],
          DW'(v + 12'h123));
    end

    // R11 halt hold
    clear_mem();
    load(0, w(5, 40)); load(1, w(9, 2)); load(2, w(0, 0));
    load(3, w(9, 2)); load(4, w(3, 41)); load(40, 12'h3C5);
    run(cyc);
    addr0 = DW'(mem_addr);
    exp = 1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!halted || DW'(mem_addr) != addr0) exp = 0;
    end
    chk(exp == 1, "R11 halted and address stable", exp, 1);
    chk(out_n == 1, "R11 no output after halt", out_n, 1);
    chk(mem[41] == 0, "R11 no store after halt", mem[41], 0);

    // R12 undefined opcodes are no-ops
    clear_mem();
    load(0, w(5, 40)); load(1, w(4, 44)); load(2, w(10, 44));
    load(3, w(15, 44)); load(4, w(9, 7)); load(5, w(3, 41));
    load(40, 12'h9A6); load(44, 12'h011);
    run(cyc);
    chk(mem[41] == 12'h9A6, "R12 accumulator unchanged", mem[41], 12'h9A6);
    chk(mem[44] == 12'h011, "R12 memory unchanged", mem[44], 12'h011);
    chk(out_n == 0 && rdy_n == 0, "R12 no strobes", out_n + rdy_n, 0);
    chk(cyc == 8 + 4 * 5 + 6 + 5, "R12 no-op timing", cyc, 39);

    // R1 reset again clears halted
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(!halted && mem_addr == 0, "R1 reset clears halt", halted, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule